// File: doc/BRIEF.md
# Configuration EEPROM Checksum Sequencer

This block moves a fixed block of 16-bit configuration words between a host-side word buffer and a word-addressed EEPROM that is reached through a command register, a data register and a completion flag. A read copies every word into the buffer and returns an additive checksum. A write stores the buffer into the EEPROM and puts a freshly computed checksum into the checksum slot. The host pulses `start` with `wr_mode` selecting the direction, waits for `done`, and then reads `checksum` and `timeout_err`.

The EEPROM address space is split into three regions:

- **Leading configuration region.** Addresses `CFG_BEGIN` up to `CFG_END-1`. Only these words are summed.
- **Checksum slot.** The single word at `CFG_END`.
- **Trailing control region.** Addresses `CTL_BEGIN` up to `WORD_END-1`. These words are copied but never summed.

Addresses that fall between `CFG_END` and `CTL_BEGIN` are never touched. In the buffer, the words sit back to back from index 0: the configuration words first, then the checksum word, then the control words.

After each command the sequencer polls the completion flag once every `POLL_INTERVAL` clock cycles, for at most `POLL_LIMIT` samples. If no sample sees the flag, it raises a sticky error and returns to idle instead of hanging.

Top module: `cfg_eeprom_seq`

## Requirements
- R1: After reset, `busy`, `done` and `timeout_err` are 0, and the block asserts no command strobe, data strobe or buffer write while it is idle.
- R2: A command word carries the operation code in bits [15:14]: 2'b10 read, 2'b01 write, 2'b11 write-enable, 2'b00 write-disable. The word address sits in the low `ADDR_W` bits, and every other bit is 0. Write-enable and write-disable carry address 0.
- R3: For every word write, `ee_data_we` with the data is asserted in the cycle directly before the write command.
- R4: A command is issued in cycle c. The completion flag is sampled in cycles c+k·`POLL_INTERVAL` (k = 1, 2, ...). The next command follows in the cycle after the first sample that sees the flag set, so two commands are never back to back.
- R5: If `POLL_LIMIT` samples all miss the flag, `timeout_err` is set, no further command is issued, and `done` pulses in cycle c+`POLL_INTERVAL`·`POLL_LIMIT`+1. `timeout_err` is cleared only by reset.
- R6: A read issues commands to addresses `CFG_BEGIN`..`CFG_END` and then `CTL_BEGIN`..`WORD_END-1`, in ascending order, and stores the returned words at buffer indices 0, 1, 2, ... in that order. Addresses between `CFG_END` and `CTL_BEGIN` are never accessed.
- R7: After a read, `checksum` equals the 16-bit wrap-around sum of the words at `CFG_BEGIN`..`CFG_END-1`. The checksum slot and the control words are excluded from the sum.
- R8: A write issues write-enable first, then one write per word in the same address order as a read, then write-disable. Each command waits for completion before the next one starts.
- R9: During a write, the checksum slot receives the 16-bit sum of the buffer's configuration words, not the buffer's own checksum word. That sum also appears on `checksum`.
- R10: `start` is accepted only while idle, and `busy` rises in the next cycle. A `start` pulse while busy changes nothing about the running sequence.
- R11: `done` is a one-cycle pulse. It is raised in the cycle after the sequence ends, and `busy` is already 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence (accepted only while idle) |
| wr_mode | input | 1 | 1 = write the buffer to the EEPROM, 0 = read the EEPROM into the buffer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| timeout_err | output | 1 | Sticky completion-timeout flag |
| checksum | output | 16 | Sum of the configuration words of the last sequence |
| buf_idx | output | IDX_W | Buffer word index |
| buf_we | output | 1 | Buffer write strobe (read sequence) |
| buf_wdata | output | 16 | Word to store in the buffer |
| buf_rdata | input | 16 | Buffer word at `buf_idx` (combinational) |
| ee_cmd_we | output | 1 | Command register write strobe |
| ee_cmd | output | 16 | Command word (operation code and address) |
| ee_data_we | output | 1 | Data register write strobe |
| ee_wdata | output | 16 | Data register write value |
| ee_rdata | input | 16 | Data register read value |
| ee_done | input | 1 | Completion flag from the command register |

## Verification
The bench builds the block with `ADDR_W`=4 and the following region layout:

- four configuration words at addresses 2..5;
- the checksum slot at address 6;
- an unused gap word at address 7;
- three control words at addresses 8..10.

This layout keeps full command logs short and leaves a gap address to watch. With `POLL_INTERVAL`=4 and `POLL_LIMIT`=5, the bench can sweep every EEPROM latency from 1 up to the last poll. The sweep shows the command spacing jumping in steps of four cycles, catches the just-in-time completion on the final sample, and reaches the timeout one cycle of latency later. Word values near 0xFFFF make the checksum wrap.

// File: rtl/cfg_eeprom_pkg.sv
package cfg_eeprom_pkg;

    typedef enum logic [1:0] {
        OPC_WDIS = 2'b00,
        OPC_WR   = 2'b01,
        OPC_RD   = 2'b10,
        OPC_WEN  = 2'b11
    } ee_opc_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_CMD,
        ST_WAIT
    } seq_st_e;

    typedef enum logic [2:0] {
        PH_WEN,
        PH_CFG,
        PH_SUM,
        PH_CTL,
        PH_WDIS
    } seq_ph_e;

endpackage

// File: rtl/eeprom_poll_timer.sv
module eeprom_poll_timer #(
    parameter int INTERVAL = 1000,
    parameter int LIMIT    = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic flag_in,
    output logic ok,
    output logic expired
);
    localparam int TICK_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam int POLL_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    typedef struct packed {
        logic              active;
        logic [TICK_W-1:0] tick;
        logic [POLL_W-1:0] polls;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic sample;

    always_comb begin
        tmr_d   = tmr_q;
        sample  = tmr_q.active && (tmr_q.tick == '0);
        ok      = sample && flag_in;
        expired = sample && !flag_in && (tmr_q.polls == POLL_W'(LIMIT - 1));
        if (arm) begin
            tmr_d.active = 1'b1;
            tmr_d.tick   = TICK_W'(INTERVAL - 1);
            tmr_d.polls  = '0;
        end else if (tmr_q.active) begin
            if (tmr_q.tick != '0) begin
                tmr_d.tick = tmr_q.tick - 1'b1;
            end else if (ok || expired) begin
                tmr_d.active = 1'b0;
            end else begin
                tmr_d.polls = tmr_q.polls + 1'b1;
                tmr_d.tick  = TICK_W'(INTERVAL - 1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

endmodule

// File: rtl/cfg_eeprom_seq.sv
module cfg_eeprom_seq
    import cfg_eeprom_pkg::*;
#(
    parameter int ADDR_W        = 6,
    parameter int CFG_BEGIN     = 0,
    parameter int CFG_END       = 21,
    parameter int CTL_BEGIN     = 22,
    parameter int WORD_END      = 40,
    parameter int POLL_INTERVAL = 1000,
    parameter int POLL_LIMIT    = 10,
    localparam int CFG_WORDS    = CFG_END - CFG_BEGIN,
    localparam int CTL_WORDS    = WORD_END - CTL_BEGIN,
    localparam int BUF_DEPTH    = CFG_WORDS + 1 + CTL_WORDS,
    localparam int IDX_W        = $clog2(BUF_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             wr_mode,
    output logic             busy,
    output logic             done,
    output logic             timeout_err,
    output logic [15:0]      checksum,
    output logic [IDX_W-1:0] buf_idx,
    output logic             buf_we,
    output logic [15:0]      buf_wdata,
    input  logic [15:0]      buf_rdata,
    output logic             ee_cmd_we,
    output logic [15:0]      ee_cmd,
    output logic             ee_data_we,
    output logic [15:0]      ee_wdata,
    input  logic [15:0]      ee_rdata,
    input  logic             ee_done
);
    localparam int PAD_W = 14 - ADDR_W;

    typedef struct packed {
        seq_st_e           st;
        seq_ph_e           ph;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [IDX_W-1:0]  idx;
        logic [15:0]       sum;
        logic              done;
        logic              err;
    } seq_t;

    seq_t              seq_d, seq_q;
    logic              poll_ok, poll_expired, poll_arm;
    ee_opc_e           opc;
    logic [ADDR_W-1:0] cmd_addr;
    logic              is_word;
    seq_ph_e           ph_n;
    logic [ADDR_W-1:0] addr_n;
    logic              fin;

    eeprom_poll_timer #(
        .INTERVAL(POLL_INTERVAL),
        .LIMIT   (POLL_LIMIT)
    ) u_poll (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (poll_arm),
        .flag_in(ee_done),
        .ok     (poll_ok),
        .expired(poll_expired)
    );

    always_comb begin
        is_word = (seq_q.ph == PH_CFG) || (seq_q.ph == PH_SUM) || (seq_q.ph == PH_CTL);
        case (seq_q.ph)
            PH_WEN:  opc = OPC_WEN;
            PH_WDIS: opc = OPC_WDIS;
            default: opc = seq_q.wr ? OPC_WR : OPC_RD;
        endcase
        cmd_addr = is_word ? seq_q.addr : '0;
    end

    assign ee_cmd      = {opc, {PAD_W{1'b0}}, cmd_addr};
    assign ee_wdata    = (seq_q.ph == PH_SUM) ? seq_q.sum : buf_rdata;
    assign buf_idx     = seq_q.idx;
    assign buf_wdata   = ee_rdata;
    assign busy        = (seq_q.st != ST_IDLE);
    assign done        = seq_q.done;
    assign timeout_err = seq_q.err;
    assign checksum    = seq_q.sum;
    assign poll_arm    = (seq_q.st == ST_CMD);

    always_comb begin
        ph_n   = seq_q.ph;
        addr_n = seq_q.addr;
        fin    = 1'b0;
        case (seq_q.ph)
            PH_WEN: begin
                ph_n   = PH_CFG;
                addr_n = ADDR_W'(CFG_BEGIN);
            end
            PH_CFG: begin
                if (seq_q.addr == ADDR_W'(CFG_END - 1)) begin
                    ph_n   = PH_SUM;
                    addr_n = ADDR_W'(CFG_END);
                end else begin
                    addr_n = seq_q.addr + 1'b1;
                end
            end
            PH_SUM: begin
                ph_n   = PH_CTL;
                addr_n = ADDR_W'(CTL_BEGIN);
            end
            PH_CTL: begin
                if (seq_q.addr == ADDR_W'(WORD_END - 1)) begin
                    if (seq_q.wr) ph_n = PH_WDIS;
                    else          fin  = 1'b1;
                end else begin
                    addr_n = seq_q.addr + 1'b1;
                end
            end
            default: fin = 1'b1;
        endcase
    end

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        ee_cmd_we  = 1'b0;
        ee_data_we = 1'b0;
        buf_we     = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    seq_d.wr   = wr_mode;
                    seq_d.sum  = '0;
                    seq_d.idx  = '0;
                    seq_d.addr = ADDR_W'(CFG_BEGIN);
                    seq_d.ph   = wr_mode ? PH_WEN : PH_CFG;
                    seq_d.st   = ST_CMD;
                end
            end
            ST_DATA: begin
                ee_data_we = 1'b1;
                if (seq_q.ph == PH_CFG) seq_d.sum = seq_q.sum + buf_rdata;
                seq_d.st = ST_CMD;
            end
            ST_CMD: begin
                ee_cmd_we = 1'b1;
                seq_d.st  = ST_WAIT;
            end
            default: begin
                if (poll_expired) begin
                    seq_d.err  = 1'b1;
                    seq_d.done = 1'b1;
                    seq_d.st   = ST_IDLE;
                end else if (poll_ok) begin
                    if (!seq_q.wr && is_word) begin
                        buf_we = 1'b1;
                        if (seq_q.ph == PH_CFG) seq_d.sum = seq_q.sum + ee_rdata;
                    end
                    if (is_word) seq_d.idx = seq_q.idx + 1'b1;
                    seq_d.ph   = ph_n;
                    seq_d.addr = addr_n;
                    if (fin) begin
                        seq_d.done = 1'b1;
                        seq_d.st   = ST_IDLE;
                    end else if (seq_q.wr && (ph_n != PH_WDIS)) begin
                        seq_d.st = ST_DATA;
                    end else begin
                        seq_d.st = ST_CMD;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q      <= '0;
            seq_q.st   <= ST_IDLE;
            seq_q.ph   <= PH_CFG;
        end else begin
            seq_q <= seq_d;
        end
    end

endmodule

// File: rtl/cfg_eeprom_seq_chk.sv
module cfg_eeprom_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        timeout_err,
    input logic        buf_we,
    input logic        ee_cmd_we,
    input logic [15:0] ee_cmd,
    input logic        ee_data_we
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ee_cmd_we && !ee_data_we && !buf_we)); // R1

    AST_CTRL_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_cmd_we && (ee_cmd[15:14] == 2'b00 || ee_cmd[15:14] == 2'b11))
        |-> (ee_cmd[13:0] == 14'd0)); // R2

    AST_DATA_BEFORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_cmd_we && ee_cmd[15:14] == 2'b01) |-> $past(ee_data_we)); // R3

    AST_CMD_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        ee_cmd_we |=> !ee_cmd_we); // R4

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |=> timeout_err); // R5

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R11
endmodule

bind cfg_eeprom_seq cfg_eeprom_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .timeout_err(timeout_err),
    .buf_we     (buf_we),
    .ee_cmd_we  (ee_cmd_we),
    .ee_cmd     (ee_cmd),
    .ee_data_we (ee_data_we)
);

// File: tb/cfg_eeprom_seq_test.sv
module cfg_eeprom_seq_test;
    localparam int AW = 4;
    localparam int CB = 2;
    localparam int CE = 6;
    localparam int CTB = 8;
    localparam int WE = 11;
    localparam int PI = 4;
    localparam int PL = 5;
    localparam int NCFG = CE - CB;
    localparam int NBUF = NCFG + 1 + (WE - CTB);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic wr_mode = 1'b0;
    logic busy, done, timeout_err;
    logic [15:0] checksum;
    logic [2:0] buf_idx;
    logic buf_we;
    logic [15:0] buf_wdata, buf_rdata;
    logic ee_cmd_we, ee_data_we;
    logic [15:0] ee_cmd, ee_wdata;
    logic [15:0] dreg = '0;
    logic dflag = 1'b0;

    logic [15:0] rom [0:15];
    logic [15:0] bufm [0:7];
    logic [15:0] lg_cmd [0:31];
    int lg_cyc [0:31];
    int ncmd = 0;
    int cyc = 0;
    int cnt = 0;
    int lat = 3;
    int last_dcyc = -10;
    int order_bad = 0;
    logic wen = 1'b0;
    logic log_clr = 1'b0;
    logic pk_en = 1'b0, pk_sel = 1'b0;
    logic [3:0] pk_idx = '0;
    logic [15:0] pk_val = '0;

    int nchecks = 0;
    int nfails = 0;

    always #4 clk = ~clk;

    cfg_eeprom_seq #(
        .ADDR_W(AW), .CFG_BEGIN(CB), .CFG_END(CE), .CTL_BEGIN(CTB),
        .WORD_END(WE), .POLL_INTERVAL(PI), .POLL_LIMIT(PL)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_mode(wr_mode),
        .busy(busy), .done(done), .timeout_err(timeout_err), .checksum(checksum),
        .buf_idx(buf_idx), .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
        .ee_cmd_we(ee_cmd_we), .ee_cmd(ee_cmd), .ee_data_we(ee_data_we),
        .ee_wdata(ee_wdata), .ee_rdata(dreg), .ee_done(dflag)
    );

    assign buf_rdata = bufm[buf_idx];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (pk_en && pk_sel) rom[pk_idx] <= pk_val;
        if (pk_en && !pk_sel) bufm[pk_idx[2:0]] <= pk_val;
        if (buf_we) bufm[buf_idx] <= buf_wdata;
        if (log_clr) ncmd <= 0;
        if (ee_data_we) begin
            dreg <= ee_wdata;
            last_dcyc <= cyc;
        end
        if (ee_cmd_we) begin
            if (!log_clr && ncmd < 32) begin
                lg_cmd[ncmd] <= ee_cmd;
                lg_cyc[ncmd] <= cyc;
                ncmd <= ncmd + 1;
            end
            dflag <= 1'b0;
            cnt <= lat;
            case (ee_cmd[15:14])
                2'b10: dreg <= rom[ee_cmd[3:0]];
                2'b01: begin
                    if (wen) rom[ee_cmd[3:0]] <= dreg;
                    if (last_dcyc != cyc - 1) order_bad <= order_bad + 1;
                end
                2'b11: wen <= 1'b1;
                default: wen <= 1'b0;
            endcase
        end else if (cnt > 1) begin
            cnt <= cnt - 1;
        end else if (cnt == 1) begin
            cnt <= 0;
            dflag <= 1'b1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchecks++;
        if (!ok) begin
            nfails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic poke(input bit sel, input int idx, input int val);
        @(negedge clk);
        pk_en = 1'b1; pk_sel = sel; pk_idx = 4'(idx); pk_val = 16'(val);
        @(negedge clk);
        pk_en = 1'b0;
    endtask

    // poke_at >= 0 pulses start (opposite direction) that many cycles into the run
    task automatic run_op(input bit wr, input int poke_at, output int dcyc);
        bit got;
        @(negedge clk);
        log_clr = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
        start = 1'b1; wr_mode = wr;
        @(negedge clk);
        start = 1'b0;
        got = 1'b0;
        dcyc = 0;
        for (int i = 0; i < 3000; i++) begin
            if (i == poke_at) begin start = 1'b1; wr_mode = !wr; end
            else start = 1'b0;
            @(negedge clk);
            if (done) begin got = 1'b1; dcyc = cyc; break; end
        end
        start = 1'b0;
        chk(got, "R11 done seen (watchdog)", got, 1);
        chk(!busy, "R11 busy low with done", busy, 0);
        @(negedge clk);
        chk(!done, "R11 done is one cycle", done, 0);
    endtask

    function automatic int exp_rd_cmd(input int k);
        int a;
        a = (k < NCFG + 1) ? CB + k : CTB + k - NCFG - 1;
        return 32'h8000 | a;
    endfunction

    function automatic int rom_sum();
        int s = 0;
        for (int a = CB; a < CE; a++) s += rom[a];
        return s & 16'hFFFF;
    endfunction

    task automatic check_read(input string tag);
        chk(ncmd == NBUF, {tag, " R6 command count"}, ncmd, NBUF);
        for (int k = 0; k < NBUF; k++) begin
            chk(lg_cmd[k] == 16'(exp_rd_cmd(k)), {tag, " R6 R2 read command"}, lg_cmd[k], exp_rd_cmd(k));
            chk(bufm[k] == rom[(k < NCFG + 1) ? CB + k : CTB + k - NCFG - 1],
                {tag, " R6 buffer word"}, bufm[k], rom[(k < NCFG + 1) ? CB + k : CTB + k - NCFG - 1]);
        end
        chk(checksum == 16'(rom_sum()), {tag, " R7 checksum"}, checksum, rom_sum());
    endtask

    initial begin
        #(8 * 150000);
        nfails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfails);
        $finish;
    end

    initial begin
        int dc, per, s, k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !timeout_err, "R1 reset state", {busy, done, timeout_err}, 0);
        chk(!ee_cmd_we && !ee_data_we && !buf_we, "R1 idle strobes", {ee_cmd_we, ee_data_we, buf_we}, 0);

        // Read, baseline pattern
        for (int a = 0; a < 16; a++) poke(1'b1, a, a * 16'h1357 + 16'h0101);
        lat = 3;
        run_op(1'b0, -1, dc);
        check_read("read-A");
        chk(lg_cyc[1] - lg_cyc[0] == PI + 1, "R4 spacing lat 3", lg_cyc[1] - lg_cyc[0], PI + 1);

        // Read with wrap-around sum; checksum slot value must not count
        for (int a = 0; a < 16; a++) poke(1'b1, a, 16'hFFFF);
        poke(1'b1, CE, 16'h1234);
        run_op(1'b0, -1, dc);
        check_read("read-wrap");
        chk(checksum == 16'hFFFC, "R7 wrap value", checksum, 16'hFFFC);

        // Latency sweep up to the last poll
        for (int l = 1; l < PI * PL; l++) begin
            lat = l;
            for (int a = 0; a < 16; a++) poke(1'b1, a, a * 16'h0F0F + l * 16'h2003);
            run_op(1'b0, -1, dc);
            check_read("sweep");
            per = PI * ((l + PI) / PI) + 1;
            chk(lg_cyc[1] - lg_cyc[0] == per, "R4 command spacing", lg_cyc[1] - lg_cyc[0], per);
            chk(!timeout_err, "R5 no timeout within limit", timeout_err, 0);
        end

        // Write with a bogus checksum word in the buffer
        lat = 2;
        for (int a = 0; a < 16; a++) poke(1'b1, a, 16'h5A5A);
        poke(1'b0, 0, 16'hFFFF); poke(1'b0, 1, 16'hFFFF);
        poke(1'b0, 2, 16'h8000); poke(1'b0, 3, 16'h8001);
        poke(1'b0, 4, 16'hDEAD);
        poke(1'b0, 5, 16'h0A0A); poke(1'b0, 6, 16'h0B0B); poke(1'b0, 7, 16'h0C0C);
        s = (16'hFFFF + 16'hFFFF + 16'h8000 + 16'h8001) & 16'hFFFF;
        run_op(1'b1, -1, dc);
        chk(ncmd == NBUF + 2, "R8 write command count", ncmd, NBUF + 2);
        chk(lg_cmd[0] == 16'hC000, "R8 R2 enable first", lg_cmd[0], 16'hC000);
        chk(lg_cmd[NBUF + 1] == 16'h0000, "R8 R2 disable last", lg_cmd[NBUF + 1], 0);
        for (int j = 0; j < NBUF; j++) begin
            k = exp_rd_cmd(j) & 16'h3FFF;
            chk(lg_cmd[j + 1] == 16'(32'h4000 | k), "R8 R2 write command", lg_cmd[j + 1], 32'h4000 | k);
        end
        chk(order_bad == 0, "R3 data before write command", order_bad, 0);
        for (int j = 0; j < NCFG; j++)
            chk(rom[CB + j] == bufm[j], "R8 config word stored", rom[CB + j], bufm[j]);
        for (int j = 0; j < WE - CTB; j++)
            chk(rom[CTB + j] == bufm[NCFG + 1 + j], "R8 control word stored", rom[CTB + j], bufm[NCFG + 1 + j]);
        chk(rom[CE] == 16'(s), "R9 checksum slot", rom[CE], s);
        chk(checksum == 16'(s), "R9 checksum output", checksum, s);
        chk(rom[CE + 1] == 16'h5A5A, "R6 gap word untouched", rom[CE + 1], 16'h5A5A);
        chk(!wen, "R8 writes disabled at end", wen, 0);

        // Read back, with a stray start while busy
        run_op(1'b0, 7, dc);
        check_read("R10 readback");
        chk(bufm[NCFG] == 16'(s), "R9 R10 slot reads back", bufm[NCFG], s);
        chk(rom[CB] == 16'hFFFF, "R10 no write from stray start", rom[CB], 16'hFFFF);

        // Timeout: latency one past the last poll
        lat = PI * PL;
        run_op(1'b0, -1, dc);
        chk(timeout_err, "R5 timeout flagged", timeout_err, 1);
        chk(ncmd == 1, "R5 no command after timeout", ncmd, 1);
        chk(dc - lg_cyc[0] == PI * PL + 1, "R5 timeout timing", dc - lg_cyc[0], PI * PL + 1);

        // Sticky after a good run
        lat = 1;
        run_op(1'b0, -1, dc);
        check_read("after-timeout");
        chk(timeout_err, "R5 error stays set", timeout_err, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfails);
        $finish;
    end
endmodule